// File: doc/BRIEF.md
# Microstepping Stepper Motor Translator

This block turns a stream of step pulses into current commands for the two windings of a bipolar stepper motor. The position within one electrical cycle is kept as an index of 32 fine positions, 11.25 degrees apart. Each rising edge on the step-pulse input moves that index forwards or backwards. The distance moved depends on the resolution chosen by a 2-bit select input: a full, half, quarter or eighth step.

From the index the block derives a 4-bit magnitude and a polarity bit for each winding. The values follow a quantized sine for winding A and a cosine for winding B, and a downstream current regulator uses them as its reference. An origin flag marks the 45-degree position. That position is the reset point and is reachable in every resolution.

The step pulse passes through a synchronizer. The direction and resolution inputs are sampled on the same clock that applies the step. A drive-enable input blanks both magnitudes without losing the position. A re-home input sends the index back to the origin.

Top module: `ustep_translator`

## Requirements
- R1: Each rising edge of `pulse_i` moves the index by exactly one step at the current resolution. A level held high produces no further steps.
- R2: `res_sel_i` sets the index stride: 2'b00 adds or subtracts 8 (full), 2'b01 moves 4 (half), 2'b10 moves 2 (quarter) and 2'b11 moves 1 (eighth).
- R3: With `fwd_i`=1 the stride is added to the index, and with `fwd_i`=0 it is subtracted. Both wrap modulo 32.
- R4: In full resolution the index first snaps to the 45-degree point of its quadrant, with the low three bits set to 3'b100. The stride of 8 is then applied, so a full step always lands on a point where both windings carry equal current.
- R5: For index i, winding A magnitude is round(15·|sin(i·11.25°)|) and winding B magnitude is round(15·|cos(i·11.25°)|). The quarter-wave codes for i = 0 to 8 are 0, 3, 6, 8, 11, 12, 14, 15, 15.
- R6: The winding A polarity bit is 1 for i < 16 and 0 otherwise. The winding B polarity bit is 1 for i < 8 or i ≥ 24 and 0 otherwise.
- R7: `at_origin_o` is 1 exactly when the index is 4, the 45-degree position.
- R8: A high `rehome_i` sets the index to 4 on the next clock, and it wins over a step applied on the same clock.
- R9: While `drive_en_i` is 0 both magnitude outputs are 0. Polarity outputs and the origin flag keep following the index, and pulses still move the index.
- R10: After `rst` the index is 4, so the outputs show magnitudes 11 and 11, both polarities 1 and the origin flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_i | input | 1 | Asynchronous step pulse, rising edge counts |
| fwd_i | input | 1 | Direction, 1 = forward |
| res_sel_i | input | 2 | Resolution select (see R2) |
| rehome_i | input | 1 | Synchronous return to the origin |
| drive_en_i | input | 1 | 1 = magnitudes driven, 0 = magnitudes forced to zero |
| ph_a_mag_o | output | 4 | Winding A current magnitude code |
| ph_a_pol_o | output | 1 | Winding A polarity |
| ph_b_mag_o | output | 4 | Winding B current magnitude code |
| ph_b_pol_o | output | 1 | Winding B polarity |
| at_origin_o | output | 1 | Index is at the origin |

## Verification
The hardest case to reach is a re-home request on exactly the clock where a synchronized step edge is applied, since the pulse passes through two synchronizer flops first. The stimulus raises the pulse on a falling edge and lets two rising edges pass. It then drives `rehome_i` high for exactly one clock, starting from a position away from the origin. A lost priority would leave the index one step off the origin. Full sweeps in each resolution and direction compare every index against a sine and cosine computed in real arithmetic.

// File: rtl/ustep_pkg.sv
package ustep_pkg;
  typedef enum logic [1:0] {
    RES_FULL    = 2'b00,
    RES_HALF    = 2'b01,
    RES_QUARTER = 2'b10,
    RES_EIGHTH  = 2'b11
  } res_e;
endpackage

// File: rtl/ustep_pulse_sync.sv
module ustep_pulse_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pulse_i,
  output logic rise_o
);
  // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], pulse_i};
  end

  assign rise_o = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/ustep_position.sv
module ustep_position
  import ustep_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv_i,
  input  logic             fwd_i,
  input  res_e             res_i,
  input  logic             rehome_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam int POSITIONS = 1 << IDX_W;
  localparam int QUAD      = POSITIONS / 4;
  localparam int ORIGIN    = QUAD / 2;

  logic [IDX_W-1:0] idx_q, stride, base, nxt;

  always_comb begin
    stride = IDX_W'(QUAD >> int'(res_i));
    if (res_i == RES_FULL)
      base = (idx_q & ~IDX_W'(QUAD - 1)) | IDX_W'(ORIGIN);
    else
      base = idx_q;
    nxt = fwd_i ? base + stride : base - stride;
  end

  always_ff @(posedge clk) begin
    if (rst)           idx_q <= IDX_W'(ORIGIN);
    else if (rehome_i) idx_q <= IDX_W'(ORIGIN);
    else if (adv_i)    idx_q <= nxt;
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/ustep_sine_lut.sv
module ustep_sine_lut #(
  parameter int IDX_W = 5,
  parameter int MAG_W = 4
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [MAG_W-1:0] mag_o,
  output logic             pol_o
);
  localparam int QW   = IDX_W - 2;
  localparam int QUAD = 1 << QW;

  logic [QW:0] arg;

  // quarter-wave, 8 fine positions per quadrant, full scale 15
  function automatic logic [MAG_W-1:0] quarter_wave(input logic [QW:0] a);
    case (int'(a))
      0:       return MAG_W'(0);
      1:       return MAG_W'(3);
      2:       return MAG_W'(6);
      3:       return MAG_W'(8);
      4:       return MAG_W'(11);
      5:       return MAG_W'(12);
      6:       return MAG_W'(14);
      default: return MAG_W'(15);
    endcase
  endfunction

  always_comb begin
    // odd quadrants run the wave backwards
    if (idx_i[QW]) arg = (QW+1)'(QUAD) - {1'b0, idx_i[QW-1:0]};
    else           arg = {1'b0, idx_i[QW-1:0]};
    mag_o = quarter_wave(arg);
    pol_o = ~idx_i[IDX_W-1];
  end
endmodule

// File: rtl/ustep_translator.sv
module ustep_translator
  import ustep_pkg::*;
#(
  parameter int IDX_W       = 5,
  parameter int MAG_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pulse_i,
  input  logic             fwd_i,
  input  logic [1:0]       res_sel_i,
  input  logic             rehome_i,
  input  logic             drive_en_i,
  output logic [MAG_W-1:0] ph_a_mag_o,
  output logic             ph_a_pol_o,
  output logic [MAG_W-1:0] ph_b_mag_o,
  output logic             ph_b_pol_o,
  output logic             at_origin_o
);
  localparam int NUM_PH = 2;
  localparam int QUAD   = (1 << IDX_W) / 4;
  localparam int ORIGIN = QUAD / 2;

  logic             adv;
  logic [IDX_W-1:0] idx_q;
  res_e             res;
  logic [MAG_W-1:0] lut_mag [NUM_PH];
  logic             lut_pol [NUM_PH];
  logic [MAG_W-1:0] mag_q   [NUM_PH];
  logic             pol_q   [NUM_PH];
  logic             origin_q;

  assign res = res_e'(res_sel_i);

  ustep_pulse_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rst     (rst),
    .pulse_i (pulse_i),
    .rise_o  (adv)
  );

  ustep_position #(.IDX_W(IDX_W)) pos_i (
    .clk      (clk),
    .rst      (rst),
    .adv_i    (adv),
    .fwd_i    (fwd_i),
    .res_i    (res),
    .rehome_i (rehome_i),
    .idx_o    (idx_q)
  );

  // each winding reads the wave shifted by a quarter cycle
  for (genvar p = 0; p < NUM_PH; p++) begin : g_phase
    localparam logic [IDX_W-1:0] OFS = IDX_W'(p * QUAD);
    logic [IDX_W-1:0] ph_idx;
    assign ph_idx = idx_q + OFS;

    ustep_sine_lut #(.IDX_W(IDX_W), .MAG_W(MAG_W)) lut_i (
      .idx_i (ph_idx),
      .mag_o (lut_mag[p]),
      .pol_o (lut_pol[p])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        mag_q[p] <= '0;
        pol_q[p] <= 1'b0;
      end else begin
        mag_q[p] <= drive_en_i ? lut_mag[p] : '0;
        pol_q[p] <= lut_pol[p];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) origin_q <= 1'b0;
    else     origin_q <= (idx_q == IDX_W'(ORIGIN));
  end

  assign ph_a_mag_o  = mag_q[0];
  assign ph_a_pol_o  = pol_q[0];
  assign ph_b_mag_o  = mag_q[1];
  assign ph_b_pol_o  = pol_q[1];
  assign at_origin_o = origin_q;
endmodule

// File: rtl/ustep_translator_chk.sv
module ustep_translator_chk #(
  parameter int IDX_W = 5,
  parameter int MAG_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             adv,
  input logic [IDX_W-1:0] idx,
  input logic [1:0]       res_sel,
  input logic             fwd,
  input logic             rehome,
  input logic             drive_en,
  input logic [MAG_W-1:0] mag_a,
  input logic [MAG_W-1:0] mag_b,
  input logic             origin
);
  localparam int QUAD   = (1 << IDX_W) / 4;
  localparam int ORIGIN = QUAD / 2;

  assert_hold_without_edge_R1: assert property (@(posedge clk) disable iff (rst)
    !adv && !rehome |=> $stable(idx));

  assert_fine_forward_R3: assert property (@(posedge clk) disable iff (rst)
    adv && !rehome && res_sel == 2'b11 && fwd |=> idx == $past(idx) + IDX_W'(1));

  assert_full_on_diagonal_R4: assert property (@(posedge clk) disable iff (rst)
    adv && !rehome && res_sel == 2'b00 |=> (idx & IDX_W'(QUAD - 1)) == IDX_W'(ORIGIN));

  assert_origin_equal_R7: assert property (@(posedge clk) disable iff (rst)
    origin |-> mag_a == mag_b);

  assert_rehome_wins_R8: assert property (@(posedge clk) disable iff (rst)
    rehome |=> idx == IDX_W'(ORIGIN));

  assert_blank_when_off_R9: assert property (@(posedge clk) disable iff (rst)
    !drive_en |=> mag_a == '0 && mag_b == '0);
endmodule

bind ustep_translator ustep_translator_chk #(.IDX_W(IDX_W), .MAG_W(MAG_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .adv      (adv),
  .idx      (idx_q),
  .res_sel  (res_sel_i),
  .fwd      (fwd_i),
  .rehome   (rehome_i),
  .drive_en (drive_en_i),
  .mag_a    (ph_a_mag_o),
  .mag_b    (ph_b_mag_o),
  .origin   (at_origin_o)
);

// File: tb/ustep_translator_tb_top.sv
module ustep_translator_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pulse = 1'b0;
  logic       fwd = 1'b1;
  logic [1:0] sel = 2'b11;
  logic       rehome = 1'b0;
  logic       en = 1'b1;
  logic [3:0] mag_a, mag_b;
  logic       pol_a, pol_b, origin;

  int checks = 0;
  int errors = 0;
  int m = 4;      // model index
  bit m_en = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  ustep_translator dut_i (
    .clk         (clk),
    .rst         (rst),
    .pulse_i     (pulse),
    .fwd_i       (fwd),
    .res_sel_i   (sel),
    .rehome_i    (rehome),
    .drive_en_i  (en),
    .ph_a_mag_o  (mag_a),
    .ph_a_pol_o  (pol_a),
    .ph_b_mag_o  (mag_b),
    .ph_b_pol_o  (pol_b),
    .at_origin_o (origin)
  );

  function automatic int exp_mag(input int i, input bit use_cos);
    real a, v;
    a = i * 3.14159265358979 / 16.0;
    v = use_cos ? $cos(a) : $sin(a);
    if (v < 0.0) v = -v;
    return $rtoi(v * 15.0 + 0.5);
  endfunction

  task automatic check_val(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s at index %0d: got %0d expected %0d", req, what, m, act, exp);
    end
  endtask

  // compares all outputs against the model index (R5, R6, R7, R9)
  task automatic check_all(input string req);
    check_val({req, "/R5"}, "mag A", int'(mag_a), m_en ? exp_mag(m, 1'b0) : 0);
    check_val({req, "/R5"}, "mag B", int'(mag_b), m_en ? exp_mag(m, 1'b1) : 0);
    check_val({req, "/R6"}, "pol A", int'(pol_a), (m < 16) ? 1 : 0);
    check_val({req, "/R6"}, "pol B", int'(pol_b), (m < 8 || m >= 24) ? 1 : 0);
    check_val({req, "/R7"}, "origin", int'(origin), (m == 4) ? 1 : 0);
  endtask

  function automatic int model_step(input int cur, input bit f, input logic [1:0] s);
    int b, st;
    b  = (s == 2'b00) ? ((cur & ~7) | 4) : cur;
    st = 8 >> s;
    return f ? (b + st) % 32 : (b - st + 32) % 32;
  endfunction

  task automatic do_pulse(input bit f, input logic [1:0] s);
    @(negedge clk);
    fwd = f; sel = s; pulse = 1'b1;
    repeat (4) @(negedge clk);
    pulse = 1'b0;
    repeat (4) @(negedge clk);
    m = model_step(m, f, s);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state is the origin
    check_all("R10");

    // R1 R3: eighth steps forward over a whole cycle, then backward
    for (int i = 0; i < 32; i++) begin do_pulse(1'b1, 2'b11); check_all("R1"); end
    for (int i = 0; i < 32; i++) begin do_pulse(1'b0, 2'b11); check_all("R3"); end

    // R1: a level held high gives one step only
    @(negedge clk);
    fwd = 1'b1; sel = 2'b11; pulse = 1'b1;
    repeat (20) @(negedge clk);
    m = model_step(m, 1'b1, 2'b11);
    check_all("R1");
    pulse = 1'b0;
    repeat (4) @(negedge clk);
    check_all("R1");

    // R2: quarter forward, half backward
    for (int i = 0; i < 16; i++) begin do_pulse(1'b1, 2'b10); check_all("R2"); end
    for (int i = 0; i < 8; i++)  begin do_pulse(1'b0, 2'b01); check_all("R2"); end

    // R4: full steps from off-diagonal positions snap to the 45-degree points
    do_pulse(1'b1, 2'b11); do_pulse(1'b1, 2'b11); do_pulse(1'b1, 2'b11);
    check_all("R4");
    for (int i = 0; i < 5; i++) begin do_pulse(1'b1, 2'b00); check_all("R4"); end
    do_pulse(1'b0, 2'b11);
    for (int i = 0; i < 5; i++) begin do_pulse(1'b0, 2'b00); check_all("R4"); end

    // R9: disabled drive blanks magnitudes, position keeps moving
    @(negedge clk); en = 1'b0; m_en = 1'b0;
    repeat (3) @(negedge clk);
    check_all("R9");
    for (int i = 0; i < 3; i++) begin do_pulse(1'b1, 2'b10); check_all("R9"); end
    @(negedge clk); en = 1'b1; m_en = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R9");

    // R8: plain re-home
    do_pulse(1'b1, 2'b11);
    @(negedge clk); rehome = 1'b1;
    @(negedge clk); rehome = 1'b0;
    m = 4;
    repeat (3) @(negedge clk);
    check_all("R8");

    // R8: re-home on the very clock that applies a step
    for (int i = 0; i < 6; i++) do_pulse(1'b1, 2'b11);
    check_all("R8");
    @(negedge clk); fwd = 1'b1; sel = 2'b11; pulse = 1'b1;
    @(negedge clk);
    @(negedge clk); rehome = 1'b1;
    @(negedge clk); rehome = 1'b0; pulse = 1'b0;
    m = 4;
    repeat (4) @(negedge clk);
    check_all("R8");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule